// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits beside a direct-mapped cache and keeps the lines that cache has recently thrown out. Its purpose is to recover conflict misses: two blocks that share one index can otherwise keep evicting each other. When the main cache misses, the controller presents the missing block address to this buffer. In the same cycle it also presents the line it is displacing from that index, if there is one. Every entry is compared against the full block address at once, and the answer comes back combinationally in the same cycle.

On a hit, the buffer returns the stored line and its dirty flag. At the next clock edge the displaced line takes over the entry that hit, so the two lines trade places. If nothing was displaced, the entry that hit is freed. On a miss, the displaced line is stored. A free entry is used if one exists; otherwise the least recently used entry is replaced. If the replaced entry is dirty, its address and data appear on a write-back output in that same cycle. Any entry that is written by a swap or a fill becomes the most recently used.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is empty: a lookup gives `hit`=0, and a fill into the empty buffer gives `wb_valid`=0.
- R2: With `req_valid`=1, `hit` is 1 in the same cycle exactly when a valid entry holds a block address equal to `req_addr` in all ADDR_W bits. In that case `hit_data` and `hit_dirty` show that entry's line and dirty flag.
- R3: Swap. A hit with `evict_valid`=1 stores the evicted address, data and dirty flag in the entry that hit. From the next cycle the evicted address hits with that data, and the old address misses.
- R4: A hit with `evict_valid`=0 frees the entry that hit. From the next cycle its address misses.
- R5: A miss with `evict_valid`=1 stores the evicted line. While any entry is empty, the lowest-numbered empty entry is used and nothing is written back.
- R6: A miss with `evict_valid`=1 into a full buffer replaces the entry least recently written by a swap or a fill.
- R7: `wb_valid` is 1 in the same cycle only when an entry is replaced under R6 and that entry is dirty. `wb_addr` and `wb_data` then show the replaced line.
- R8: With `req_valid`=0 the inputs are ignored: `hit` and `wb_valid` stay 0, and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| req_valid | input | 1 | Main cache missed; a lookup is requested this cycle |
| req_addr | input | ADDR_W | Full block address of the missing line |
| evict_valid | input | 1 | The main cache is displacing a valid line this cycle |
| evict_addr | input | ADDR_W | Block address of the displaced line |
| evict_data | input | DATA_W | Data of the displaced line |
| evict_dirty | input | 1 | The displaced line is modified |
| hit | output | 1 | The requested block is held in the buffer |
| hit_data | output | DATA_W | Data of the entry that hit |
| hit_dirty | output | 1 | Dirty flag of the entry that hit |
| wb_valid | output | 1 | A dirty entry is replaced this cycle and must be written to memory |
| wb_addr | output | ADDR_W | Block address of the replaced dirty line |
| wb_data | output | DATA_W | Data of the replaced dirty line |

## Verification
The lookup and the write of the displaced line fall in the same cycle. On a swap, the entry being read is also the entry being overwritten, so the returned data must be the old contents and the new line must become visible only from the following cycle. The bench provokes this by steering about half of its requests to addresses known to be resident while a displaced line is also presented. It judges the outcome with an independent model of the entries and of a recency list. Back-to-back lookups of the swapped-in and swapped-out addresses confirm which line now occupies the slot.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_IDLE = 2'd0,
    VC_SWAP = 2'd1,
    VC_DROP = 2'd2,
    VC_FILL = 2'd3
  } vc_op_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 4,
  parameter int AW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         ent_valid,
  input  logic [N-1:0][AW-1:0] ent_addr,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         match,
  output logic                 any,
  output logic [IW-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_addr[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx = IW'(i);
    end
  end

  always_comb begin
    AST_ONE_MATCH: assert ($onehot0(match)); // R2
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  logic [N-1:0][IW-1:0] age_q, age_d;
  logic [N-1:0]         seen;

  always_comb begin
    age_d = age_q;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) == touch_idx) begin
        age_d[i] = '0;
      end else if (age_q[i] < age_q[touch_idx]) begin
        age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IW'(N - 1)) lru_idx = IW'(i);
    end
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) seen[age_q[i]] = 1'b1;
  end

  AST_AGES_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N); // R6
endmodule

// File: rtl/vc_pick.sv
module vc_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  ent_valid,
  input  logic [IW-1:0] lru_idx,
  output logic [IW-1:0] slot,
  output logic          slot_taken
);
  always_comb begin
    slot = lru_idx;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) slot = IW'(i);
    end
  end

  assign slot_taken = &ent_valid;
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              hit_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import vc_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0]             dirty_q, dirty_d;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q, data_d;

  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IW-1:0]      hit_idx, lru_idx, fill_idx, wr_idx;
  logic               full;
  vc_op_e             op;
  logic               upd_en;

  vc_match #(.N(ENTRIES), .AW(ADDR_W)) u_match (
    .ent_valid (valid_q),
    .ent_addr  (addr_q),
    .key       (req_addr),
    .match     (match),
    .any       (any_match),
    .idx       (hit_idx)
  );

  vc_pick #(.N(ENTRIES)) u_pick (
    .ent_valid  (valid_q),
    .lru_idx    (lru_idx),
    .slot       (fill_idx),
    .slot_taken (full)
  );

  vc_lru #(.N(ENTRIES)) u_lru (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .touch_en  (upd_en),
    .touch_idx (wr_idx),
    .lru_idx   (lru_idx)
  );

  always_comb begin
    op = VC_IDLE;
    if (req_valid) begin
      if (any_match) op = evict_valid ? VC_SWAP : VC_DROP;
      else if (evict_valid) op = VC_FILL;
    end
  end

  assign upd_en    = (op != VC_IDLE);
  assign wr_idx    = any_match ? hit_idx : fill_idx;
  assign hit       = req_valid && any_match;
  assign hit_data  = data_q[hit_idx];
  assign hit_dirty = dirty_q[hit_idx];
  assign wb_valid  = (op == VC_FILL) && full && dirty_q[fill_idx];
  assign wb_addr   = addr_q[fill_idx];
  assign wb_data   = data_q[fill_idx];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    addr_d  = addr_q;
    data_d  = data_q;
    case (op)
      VC_SWAP, VC_FILL: begin
        valid_d[wr_idx] = 1'b1;
        dirty_d[wr_idx] = evict_dirty;
        addr_d[wr_idx]  = evict_addr;
        data_d[wr_idx]  = evict_data;
      end
      VC_DROP: valid_d[wr_idx] = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      dirty_q <= dirty_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  AST_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_valid |-> (req_valid && evict_valid && !hit)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> $stable(valid_q)); // R8
  AST_SWAP_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && evict_valid) |=>
      (valid_q[$past(hit_idx)] && addr_q[$past(hit_idx)] == $past(evict_addr))); // R3
  AST_DROP_FREES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && !evict_valid) |=> !valid_q[$past(hit_idx)]); // R4
  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !hit && evict_valid) |=> valid_q[$past(fill_idx)]); // R5
endmodule

// File: tb/victim_buf_test.sv
module victim_buf_test;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic [DW-1:0] evict_data = '0;
  logic          evict_dirty = 1'b0;
  logic          hit, hit_dirty, wb_valid;
  logic [DW-1:0] hit_data, wb_data;
  logic [AW-1:0] wb_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  victim_buf #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .evict_data(evict_data), .evict_dirty(evict_dirty),
    .hit(hit), .hit_data(hit_data), .hit_dirty(hit_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // independent model: entries plus a recency list, index 0 = most recent
  logic          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [DW-1:0] m_d [N];
  logic          m_dy[N];
  int            ord [N];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic touch(int k);
    int p = 0;
    for (int i = 0; i < N; i++) if (ord[i] == k) p = i;
    for (int i = p; i > 0; i--) ord[i] = ord[i-1];
    ord[0] = k;
  endtask

  function automatic bit resident(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // one operation: drive after the falling edge, compare, update the model
  task automatic do_op(logic rv, logic [AW-1:0] ra, logic ev, logic [AW-1:0] ea,
                       logic [DW-1:0] ed, logic edy, string htag, string wtag);
    int hk = -1;
    int slot = -1;
    logic ex_wb = 1'b0;
    @(negedge clk);
    req_valid = rv; req_addr = ra; evict_valid = ev;
    evict_addr = ea; evict_data = ed; evict_dirty = edy;
    #2;
    if (rv) for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == ra) hk = i;
    chk(htag, "hit", 32'(hit), 32'(hk >= 0));
    if (hk >= 0) begin
      chk(htag, "hit_data", 32'(hit_data), 32'(m_d[hk]));
      chk(htag, "hit_dirty", 32'(hit_dirty), 32'(m_dy[hk]));
    end
    if (rv && hk < 0 && ev) begin
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = ord[N-1];
        ex_wb = m_dy[slot];
      end
    end
    chk(wtag, "wb_valid", 32'(wb_valid), 32'(ex_wb));
    if (ex_wb) begin
      chk(wtag, "wb_addr", 32'(wb_addr), 32'(m_a[slot]));
      chk(wtag, "wb_data", 32'(wb_data), 32'(m_d[slot]));
    end
    if (hk >= 0) begin
      if (ev) begin
        m_a[hk] = ea; m_d[hk] = ed; m_dy[hk] = edy;
      end else begin
        m_v[hk] = 1'b0;
      end
      touch(hk);
    end else if (slot >= 0) begin
      m_v[slot] = 1'b1; m_a[slot] = ea; m_d[slot] = ed; m_dy[slot] = edy;
      touch(slot);
    end
  endtask

  task automatic reset_all();
    rst_n = 1'b0;
    req_valid = 1'b0; evict_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_a[i] = '0; m_d[i] = '0; m_dy[i] = 1'b0; ord[i] = i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    reset_all();

    // R1: empty after reset
    do_op(1'b1, 6'd0, 1'b0, 6'd0, 8'h00, 1'b0, "R1", "R1");
    do_op(1'b1, 6'd9, 1'b0, 6'd0, 8'h00, 1'b0, "R1", "R1");

    // R5: fills into the empty buffer, no write-back
    for (int i = 1; i <= N; i++)
      do_op(1'b1, 6'd40, 1'b1, 6'(i), 8'(8'h10 + i), 1'b1, "R5", "R5");

    // R8: idle request with a resident address is ignored
    do_op(1'b0, 6'd2, 1'b1, 6'd50, 8'hEE, 1'b1, "R8", "R8");
    chk("R8", "idle hit", 32'(hit), 32'd0);

    // R3: swap line 1 with line 5, then probe both
    do_op(1'b1, 6'd1, 1'b1, 6'd5, 8'h55, 1'b0, "R3", "R3");
    do_op(1'b1, 6'd1, 1'b0, 6'd0, 8'h00, 1'b0, "R3", "R3");
    chk("R3", "old line gone", 32'(hit), 32'd0);
    do_op(1'b1, 6'd5, 1'b1, 6'd7, 8'h77, 1'b0, "R3", "R3");
    chk("R3", "swapped-in data", 32'(hit_data), 32'h55);

    // R6 + R7: entry 1 (address 2) is now least recent; it is dirty
    do_op(1'b1, 6'd41, 1'b1, 6'd6, 8'h66, 1'b0, "R6", "R7");
    chk("R6", "lru victim addr", 32'(wb_addr), 32'd2);

    // R4: hit without an evicted line frees the entry
    do_op(1'b1, 6'd3, 1'b0, 6'd0, 8'h00, 1'b0, "R4", "R4");
    do_op(1'b1, 6'd3, 1'b0, 6'd0, 8'h00, 1'b0, "R4", "R4");
    chk("R4", "freed entry misses", 32'(hit), 32'd0);

    // R2: full-width compare, addresses differing only in the top bit
    do_op(1'b1, 6'd38, 1'b1, 6'd4 ^ 6'h20, 8'hA4, 1'b1, "R2", "R7");
    do_op(1'b1, 6'd4, 1'b0, 6'd0, 8'h00, 1'b0, "R2", "R7");

    // sweep: pseudo-random mix biased toward resident addresses
    for (int n = 0; n < 4000; n++) begin
      logic rv, ev, edy;
      logic [AW-1:0] ra, ea;
      logic [DW-1:0] ed;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rv = (lf[2:0] != 3'd0);
      ev = (lf[4:3] != 2'd0);
      edy = lf[5];
      ed = lf[15:8];
      ra = 6'(lf[11:6]);
      if (lf[7] && m_v[lf[9:8]]) ra = m_a[lf[9:8]];
      ea = 6'(lf[15:10] ^ lf[5:0]);
      while (resident(ea) || ea == ra) ea = ea + 6'd1;
      do_op(rv, ra, ev, ea, ed, edy, rv ? "R2" : "R8", "R7");
      if (n == 2000) reset_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule